// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block is the digital front end of a 10-bit current-steering DAC built with a 7+3 segmentation. Each clock cycle it can accept one input word. The upper seven bits become a unary thermometer word that drives 127 equally weighted switch cells. The lower three bits keep their binary weights and drive three binary-weighted cells. Every control leaves the block as a complementary pair, because each switch-cell latch needs both polarities.

The thermometer decode runs in two registered steps. The first step is a row/column pre-decode. The second step combines the rows and columns into the unary bits. The three binary bits travel through a delay line with the same number of flops, so both groups of outputs change on the same clock edge. A register sits at the input and at every output, and every path inside runs from one flop to the next. A valid qualifier moves through the pipeline next to the data. The output bank loads only when a valid word arrives, and otherwise keeps its last value.

Top module: `segdac_front`

## Requirements
- R1: When the upper field (input bits 9..3) holds the value N, exactly the thermometer outputs therm_p[0] to therm_p[N-1] are high and all other thermometer outputs are low.
- R2: Input bits 2..0 appear unchanged on bin_p, with bin_p[0] carrying input bit 0 (weight 1) and bin_p[2] carrying input bit 2 (weight 4).
- R3: A word that is sampled with code_vld high on clock edge k appears on all outputs just after edge k+3. The thermometer and binary groups change on that same edge.
- R4: Words that are presented with code_vld high on consecutive cycles each appear on consecutive cycles, in order, and none is lost.
- R5: In every cycle after reset, therm_n is the bitwise inverse of therm_p and bin_n is the bitwise inverse of bin_p.
- R6: A synchronous active-high rst clears the whole pipeline. After any edge with rst high, therm_p and bin_p are all zero and therm_n and bin_n are all ones. A word that was in flight when reset hit never reaches the outputs.
- R7: A word that is sampled with code_vld low has no effect. Three edges later the outputs keep the values they already held.
- R8: The boundary fields behave as R1 requires. N=0 gives all 127 thermometer outputs low, N=127 gives all of them high, and the row-crossing values 15 and 16 (8 outputs per row) give 15 and 16 high outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all flops trigger on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 10 | Input code; bits 9..3 are the unary field, bits 2..0 the binary field |
| code_vld | input | 1 | Qualifies code_in in the same cycle |
| therm_p | output | 127 | Unary switch controls, true polarity |
| therm_n | output | 127 | Unary switch controls, inverted polarity |
| bin_p | output | 3 | Binary-weighted switch controls, true polarity |
| bin_n | output | 3 | Binary-weighted switch controls, inverted polarity |

## Verification
A table of codes is streamed back to back. It covers codes 0 and 1023, unary fields at the row edges (15, 16, 63, 64, 126), and alternating bit patterns. These separate an off-by-one in the row or column compare from a swapped row and column split. They also catch a binary path whose delay is wrong by one, because neighbouring table words differ in both fields. Further directed sequences insert invalid words carrying different codes, which shows whether the hold works. A reset applied while words are still in flight shows whether stale data leaks out.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    // Default segmentation of the converter code.
    localparam int UNARY_FIELD_W = 7;
    localparam int BINARY_FIELD_W = 3;

    // Number of unary cells driven by a field of the given width.
    function automatic int unary_cells(input int field_w);
        return (1 << field_w) - 1;
    endfunction

    // Column bits used by the row/column pre-decode.
    function automatic int col_bits(input int field_w);
        return field_w / 2;
    endfunction
endpackage

// File: rtl/seg_predecode.sv
module seg_predecode #(
    parameter int FIELD_W = 7,
    parameter int COL_W   = 3,
    localparam int ROW_W  = FIELD_W - COL_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int COLS   = 1 << COL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field,
    output logic [ROWS-1:0]    row_below,
    output logic [ROWS-1:0]    row_equal,
    output logic [COLS-1:0]    col_below
);
    logic [ROW_W-1:0] row_sel;
    logic [COL_W-1:0] col_sel;
    logic [ROWS-1:0]  row_below_d;
    logic [ROWS-1:0]  row_equal_d;
    logic [COLS-1:0]  col_below_d;

    assign row_sel = field[FIELD_W-1:COL_W];
    assign col_sel = field[COL_W-1:0];

    // Row decode: full rows below the selected row, plus a one-hot current row.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_below_d[r] = (ROW_W'(r) < row_sel);
        assign row_equal_d[r] = (ROW_W'(r) == row_sel);
    end

    // Column decode: cells of the current row that are switched on.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_below_d[c] = (COL_W'(c) < col_sel);
    end

    // Reset values equal the decode of field value 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            row_below <= '0;
            row_equal <= ROWS'(1);
            col_below <= '0;
        end else begin
            row_below <= row_below_d;
            row_equal <= row_equal_d;
            col_below <= col_below_d;
        end
    end

    // Exactly one row is the partially filled row.
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(row_equal) == 1);

    // Rows below the current one form a thermometer.
    assert_row_shape_R1: assert property (@(posedge clk) disable iff (rst)
        ((row_below + ROWS'(1)) & row_below) == '0);
endmodule

// File: rtl/seg_combine.sv
module seg_combine #(
    parameter int FIELD_W = 7,
    parameter int COL_W   = 3,
    localparam int ROW_W  = FIELD_W - COL_W,
    localparam int ROWS   = 1 << ROW_W,
    localparam int COLS   = 1 << COL_W,
    localparam int CELLS  = (1 << FIELD_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ROWS-1:0]  row_below,
    input  logic [ROWS-1:0]  row_equal,
    input  logic [COLS-1:0]  col_below,
    output logic [CELLS-1:0] unary
);
    logic [CELLS-1:0] unary_d;

    // Cell i sits at row i/COLS, column i%COLS. It is on when its row is full,
    // or when its row is the current row and its column is below the count.
    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        localparam int R = i / COLS;
        localparam int C = i % COLS;
        assign unary_d[i] = row_below[R] | (row_equal[R] & col_below[C]);
    end

    always_ff @(posedge clk) begin
        if (rst) unary <= '0;
        else     unary <= unary_d;
    end

    // The combined word is always a contiguous run of ones starting at bit 0.
    assert_unary_shape_R1: assert property (@(posedge clk) disable iff (rst)
        ((unary + CELLS'(1)) & unary) == '0);
endmodule

// File: rtl/seg_delay.sv
module seg_delay #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] tap [DEPTH+1];

    assign tap[0] = din;

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[s+1] <= '0;
            else     tap[s+1] <= tap[s];
        end
    end

    assign dout = tap[DEPTH];
endmodule

// File: rtl/segdac_front.sv
module segdac_front
    import segdac_pkg::*;
#(
    parameter int UNARY_W  = UNARY_FIELD_W,
    parameter int BINARY_W = BINARY_FIELD_W,
    localparam int CODE_W  = UNARY_W + BINARY_W,
    localparam int CELLS   = (1 << UNARY_W) - 1,
    localparam int COL_W   = UNARY_W / 2,
    localparam int ROWS    = 1 << (UNARY_W - COL_W),
    localparam int COLS    = 1 << COL_W,
    localparam int DEC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   code_in,
    input  logic                code_vld,
    output logic [CELLS-1:0]    therm_p,
    output logic [CELLS-1:0]    therm_n,
    output logic [BINARY_W-1:0] bin_p,
    output logic [BINARY_W-1:0] bin_n
);
    // Input register.
    logic [CODE_W-1:0] in_code;
    logic              in_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_code <= '0;
            in_vld  <= 1'b0;
        end else begin
            in_code <= code_in;
            in_vld  <= code_vld;
        end
    end

    // Unary path: pre-decode stage, then combine stage.
    logic [ROWS-1:0]  row_below;
    logic [ROWS-1:0]  row_equal;
    logic [COLS-1:0]  col_below;
    logic [CELLS-1:0] unary_word;

    seg_predecode #(.FIELD_W(UNARY_W), .COL_W(COL_W)) u_predecode (
        .clk       (clk),
        .rst       (rst),
        .field     (in_code[CODE_W-1:BINARY_W]),
        .row_below (row_below),
        .row_equal (row_equal),
        .col_below (col_below)
    );

    seg_combine #(.FIELD_W(UNARY_W), .COL_W(COL_W)) u_combine (
        .clk       (clk),
        .rst       (rst),
        .row_below (row_below),
        .row_equal (row_equal),
        .col_below (col_below),
        .unary     (unary_word)
    );

    // Binary bits and the valid flag get the same number of flops as the decode.
    logic [BINARY_W:0] side_dly;

    seg_delay #(.WIDTH(BINARY_W + 1), .DEPTH(DEC_STAGES)) u_bin_delay (
        .clk  (clk),
        .rst  (rst),
        .din  ({in_vld, in_code[BINARY_W-1:0]}),
        .dout (side_dly)
    );

    logic                stage_vld;
    logic [BINARY_W-1:0] stage_bin;
    assign stage_vld = side_dly[BINARY_W];
    assign stage_bin = side_dly[BINARY_W-1:0];

    // Output bank: each polarity has its own flop; it loads only on valid words.
    always_ff @(posedge clk) begin
        if (rst) begin
            therm_p <= '0;
            therm_n <= '1;
            bin_p   <= '0;
            bin_n   <= '1;
        end else if (stage_vld) begin
            therm_p <= unary_word;
            therm_n <= ~unary_word;
            bin_p   <= stage_bin;
            bin_n   <= ~stage_bin;
        end
    end

    // Cycles since reset, used only to qualify the latency check.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    assert_pair_unary_R5: assert property (@(posedge clk) disable iff (rst)
        therm_n == ~therm_p);

    assert_pair_binary_R5: assert property (@(posedge clk) disable iff (rst)
        bin_n == ~bin_p);

    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (therm_p == '0 && bin_p == '0 && therm_n == '1 && bin_n == '1));

    assert_hold_invalid_R7: assert property (@(posedge clk) disable iff (rst)
        !stage_vld |=> ($stable(therm_p) && $stable(bin_p)));

    assert_latency_unary_R3: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd3 && $past(in_vld, 3))
            |-> ($countones(therm_p) == 32'($past(in_code[CODE_W-1:BINARY_W], 3))));

    assert_latency_binary_R2: assert property (@(posedge clk) disable iff (rst)
        (warm_cnt == 2'd3 && $past(in_vld, 3))
            |-> (bin_p == $past(in_code[BINARY_W-1:0], 3)));
endmodule

// File: tb/segdac_front_bench.sv
`timescale 1ns/1ps
module segdac_front_bench;
    localparam int CELLS = 127;
    localparam int NV    = 13;

    // Entry: {code[9:0], expected unary count[6:0], expected binary[2:0]}
    localparam logic [19:0] VEC [NV] = '{
        {10'd0,    7'd0,   3'd0},
        {10'd1023, 7'd127, 3'd7},
        {10'd7,    7'd0,   3'd7},
        {10'd8,    7'd1,   3'd0},
        {10'd1016, 7'd127, 3'd0},
        {10'd512,  7'd64,  3'd0},
        {10'd511,  7'd63,  3'd7},
        {10'd341,  7'd42,  3'd5},
        {10'd682,  7'd85,  3'd2},
        {10'd120,  7'd15,  3'd0},
        {10'd128,  7'd16,  3'd0},
        {10'd1015, 7'd126, 3'd7},
        {10'd100,  7'd12,  3'd4}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [9:0]       code_in = '0;
    logic             code_vld = 1'b0;
    logic [CELLS-1:0] therm_p, therm_n;
    logic [2:0]       bin_p, bin_n;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    segdac_front u_segdac_front (
        .clk      (clk),
        .rst      (rst),
        .code_in  (code_in),
        .code_vld (code_vld),
        .therm_p  (therm_p),
        .therm_n  (therm_n),
        .bin_p    (bin_p),
        .bin_n    (bin_n)
    );

    function automatic logic [CELLS-1:0] unary_of(input int n);
        logic [CELLS-1:0] w = '0;
        for (int i = 0; i < CELLS; i++) w[i] = (i < n);
        return w;
    endfunction

    task automatic check_out(input string req, input int n, input logic [2:0] b);
        logic [CELLS-1:0] exp_t = unary_of(n);
        total++;
        if (therm_p !== exp_t || therm_n !== ~exp_t || bin_p !== b || bin_n !== ~b) begin
            bad++;
            $display("FAIL %s: therm_p=%h therm_n=%h bin_p=%b bin_n=%b expected count %0d bin %b",
                     req, therm_p, therm_n, bin_p, bin_n, n, b);
        end
    endtask

    task automatic step(input logic [9:0] c, input logic v);
        code_in  = c;
        code_vld = v;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R6: reset state
        check_out("R6 reset state", 0, 3'd0);
        rst = 1'b0;

        // R1 R2 R3 R4 R8: stream the table back to back, outputs lag four negedges
        for (int i = 0; i < NV + 4; i++) begin
            if (i >= 4)
                check_out($sformatf("R1/R2/R3/R4/R8 vector %0d", i - 4),
                          int'(VEC[i-4][9:3]), VEC[i-4][2:0]);
            if (i < NV) begin
                code_in  = VEC[i][19:10];
                code_vld = 1'b1;
            end else begin
                code_in  = 10'd3;
                code_vld = 1'b0;
            end
            @(negedge clk);
        end

        // R7: invalid words with other codes leave the last value in place
        step(10'd1023, 1'b0);
        step(10'd0, 1'b0);
        step(10'd555, 1'b0);
        step(10'd17, 1'b0);
        check_out("R7 hold after invalid words", 12, 3'd4);

        // R7 then R3: a valid word after a gap, surrounded by invalid ones
        step(10'd250, 1'b1);
        step(10'd900, 1'b0);
        step(10'd901, 1'b0);
        check_out("R3 not yet visible after two edges", 12, 3'd4);
        step(10'd902, 1'b0);
        check_out("R3 gap word at third edge", 31, 3'd2);
        step(10'd903, 1'b0);
        check_out("R7 held after gap word", 31, 3'd2);

        // R6: reset with words in flight, which must never emerge
        step(10'd1023, 1'b1);
        step(10'd1022, 1'b1);
        rst = 1'b1;
        step(10'd1021, 1'b1);
        check_out("R6 reset mid stream", 0, 3'd0);
        rst = 1'b0;
        step(10'd0, 1'b0);
        step(10'd0, 1'b0);
        step(10'd0, 1'b0);
        step(10'd0, 1'b0);
        check_out("R6 no stale word after reset", 0, 3'd0);

        // R8: top code directly after reset, then back to zero
        step(10'd1023, 1'b1);
        step(10'd0, 1'b1);
        step(10'd0, 1'b0);
        step(10'd0, 1'b0);
        check_out("R8 full scale", 127, 3'd7);
        step(10'd0, 1'b0);
        check_out("R8 zero scale", 0, 3'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule